// File: doc/BRIEF.md
# Cascaded 16-bit Match Timer

This block is a 16-bit up-counting interval timer. Two 8-bit counter stages are chained by a carry so that together they act as one 16-bit counter. Software programs it through a byte-wide register write port: a control register (run and cascade bits), a mode register (tick source and shadow-buffer enable), and two compare byte registers. While running, the counter advances on each system clock edge where the selected tick-enable input is high. When the next count would equal the active compare value, the counter returns to zero and a one-cycle interrupt pulse is issued.

The 16-bit compare value is written as two bytes. The low byte is parked in an internal latch. The write of the high byte commits both bytes as one value. With the shadow buffer enabled and the timer running, a committed value waits in a shadow register and only becomes active on the next match. In every other case it becomes active at once. When a new compare value lies below the current count, the counter runs on through 0xFFFF, wraps to zero, and only then reaches the new value.

Top module: `casc_match_timer`

## Requirements
- R1: After a synchronous reset the count output is 0x0000 and the interrupt output is low, and the count stays at zero until the timer is started.
- R2: The counter advances only when both the run bit (control register, address 0, bit 0) and the cascade bit (address 0, bit 1) are set; with run set and cascade clear the count stays 0x0000.
- R3: The tick source is chosen by mode register (address 1) bits [1:0], indexing `tick_in`; the counter increments by one only on clock edges where the selected tick input is high, and holds its value otherwise.
- R4: On a tick whose incremented count would equal the active compare value, the counter becomes 0x0000 on that edge instead, and `irq_o` is high for exactly that following cycle.
- R5: A write to the low compare byte (address 2) alone does not change the compare value; a write to the high compare byte (address 3) commits {high byte, latched low byte} as one 16-bit value.
- R6: Clearing the run bit clears the counter to 0x0000 on the next clock edge, and it stays there while stopped.
- R7: Writes to the mode register are ignored while the run bit is set.
- R8: With the shadow buffer enabled (mode bit 2 = 1) and the timer running, a committed value goes to the shadow register only; the active compare value takes the shadow value at the next match, on the same edge as that match.
- R9: With the shadow buffer enabled and the timer stopped, a committed value is loaded into both the shadow and the active compare value at once.
- R10: With the shadow buffer disabled (mode bit 2 = 0), a committed value replaces the active compare value at once, even while running.
- R11: When the active compare value is below the current count, no interrupt occurs until the counter has passed 0xFFFF, wrapped to 0x0000 and then reached the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select: 0 control, 1 mode, 2 compare low, 3 compare high |
| wr_data | input | 8 | Register write data |
| tick_in | input | 4 | Single-cycle count-enable ticks from an external prescaler |
| irq_o | output | 1 | Registered one-cycle match interrupt pulse |
| count_o | output | 16 | Current counter value |

## Verification
Every register write takes effect on the clock edge that samples it. A counter increment caused by a tick is visible right after the edge that samples that tick. The match pulse and the clear to zero appear together, right after the edge that samples the matching tick. A stop clears the counter one edge after the run bit has dropped. The bench therefore records the edge number of each write it performs and queues each expected count and interrupt value against an absolute edge number computed from it. A monitor compares them just after that edge. Shadow-buffer, immediate-update and wrap-around cases are set up so that a wrong choice of compare value shows up as a different count or pulse on a specific edge.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_MODE   = 2'd1,
    REG_CMP_LO = 2'd2,
    REG_CMP_HI = 2'd3
  } reg_addr_e;

  // control register fields
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_CASC_BIT = 1;

  // mode register fields: tick select in the low bits, shadow enable above
  localparam int MODE_DBUF_BIT = 2;

endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
  import ctm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  run_o,
  output logic                  casc_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  dbuf_o,
  output logic [DATA_W-1:0]     lo_latch_o,
  output logic                  commit_o,
  output logic [2*DATA_W-1:0]   commit_val_o
);

  logic              run_q;
  logic              casc_q;
  logic [SEL_W-1:0]  sel_q;
  logic              dbuf_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      casc_q <= 1'b0;
      sel_q  <= '0;
      dbuf_q <= 1'b0;
      lo_q   <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_CTRL: begin
          run_q  <= wr_data[CTRL_RUN_BIT];
          casc_q <= wr_data[CTRL_CASC_BIT];
        end
        REG_MODE: begin
          if (!run_q) begin
            sel_q  <= wr_data[SEL_W-1:0];
            dbuf_q <= wr_data[MODE_DBUF_BIT];
          end
        end
        REG_CMP_LO: lo_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign commit_o     = wr_en && (reg_addr_e'(wr_addr) == REG_CMP_HI);
  assign commit_val_o = {wr_data, lo_q};

  assign run_o      = run_q;
  assign casc_o     = casc_q;
  assign sel_o      = sel_q;
  assign dbuf_o     = dbuf_q;
  assign lo_latch_o = lo_q;

endmodule

// File: rtl/ctm_cmp.sv
module ctm_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_val_i,
  input  logic             dbuf_i,
  input  logic             run_i,
  input  logic             match_i,
  output logic [CNT_W-1:0] active_o,
  output logic [CNT_W-1:0] shadow_o
);

  logic [CNT_W-1:0] active_q;
  logic [CNT_W-1:0] shadow_q;
  logic             defer;

  // a commit is held back only while running with the shadow in use
  assign defer = dbuf_i && run_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (commit_i) begin
      shadow_q <= commit_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (commit_i && !defer) begin
      active_q <= commit_val_i;
    end else if (match_i && dbuf_i) begin
      active_q <= shadow_q;
    end
  end

  assign active_o = active_q;
  assign shadow_o = shadow_q;

endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int STAGE_W    = 8,
  parameter int NUM_STAGES = 2,
  localparam int CNT_W     = STAGE_W * NUM_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o,
  output logic             irq_o
);

  logic [NUM_STAGES-1:0] carry;
  logic [CNT_W-1:0]      inc_val;
  logic                  match;
  logic                  irq_q;

  assign carry[0] = en_i && tick_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic [STAGE_W-1:0] st_q;

    assign inc_val[g*STAGE_W +: STAGE_W] = st_q + {{(STAGE_W-1){1'b0}}, carry[g]};
    assign count_o[g*STAGE_W +: STAGE_W] = st_q;

    if (g < NUM_STAGES - 1) begin : g_carry
      assign carry[g+1] = carry[g] && (&st_q);
    end

    always_ff @(posedge clk) begin
      if (rst || !en_i || match) begin
        st_q <= '0;
      end else if (carry[g]) begin
        st_q <= st_q + 1'b1;
      end
    end
  end

  assign match = carry[0] && (inc_val == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= match;
    end
  end

  assign match_o = match;
  assign irq_o   = irq_q;

endmodule

// File: rtl/casc_match_timer.sv
module casc_match_timer
  import ctm_pkg::*;
#(
  parameter int STAGE_W   = 8,
  parameter int NUM_TICKS = 4,
  localparam int NUM_STAGES = 2,
  localparam int CNT_W      = STAGE_W * NUM_STAGES,
  localparam int SEL_W      = $clog2(NUM_TICKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [STAGE_W-1:0]    wr_data,
  input  logic [NUM_TICKS-1:0]  tick_in,
  output logic                  irq_o,
  output logic [CNT_W-1:0]      count_o
);

  logic               run_q;
  logic               casc_q;
  logic [SEL_W-1:0]   clk_sel_q;
  logic               dbuf_q;
  logic [STAGE_W-1:0] lo_latch_q;
  logic               commit;
  logic [CNT_W-1:0]   commit_val;
  logic [CNT_W-1:0]   active_cmp;
  logic [CNT_W-1:0]   shadow_cmp;
  logic               match;
  logic               cnt_en;
  logic               tick_sel;

  ctm_regs #(
    .DATA_W (STAGE_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .run_o        (run_q),
    .casc_o       (casc_q),
    .sel_o        (clk_sel_q),
    .dbuf_o       (dbuf_q),
    .lo_latch_o   (lo_latch_q),
    .commit_o     (commit),
    .commit_val_o (commit_val)
  );

  assign cnt_en   = run_q && casc_q;
  assign tick_sel = tick_in[clk_sel_q];

  ctm_cmp #(
    .CNT_W (CNT_W)
  ) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .commit_i     (commit),
    .commit_val_i (commit_val),
    .dbuf_i       (dbuf_q),
    .run_i        (run_q),
    .match_i      (match),
    .active_o     (active_cmp),
    .shadow_o     (shadow_cmp)
  );

  ctm_counter #(
    .STAGE_W    (STAGE_W),
    .NUM_STAGES (NUM_STAGES)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en_i    (cnt_en),
    .tick_i  (tick_sel),
    .cmp_i   (active_cmp),
    .count_o (count_o),
    .match_o (match),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/ctm_chk.sv
module ctm_chk
  import ctm_pkg::*;
#(
  parameter int STAGE_W = 8,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] wr_addr,
  input logic [STAGE_W-1:0]    wr_data,
  input logic                  run_q,
  input logic                  cnt_en,
  input logic                  tick_sel,
  input logic                  dbuf_q,
  input logic [SEL_W-1:0]      clk_sel_q,
  input logic [STAGE_W-1:0]    lo_latch_q,
  input logic [CNT_W-1:0]      active_cmp,
  input logic [CNT_W-1:0]      shadow_cmp,
  input logic [CNT_W-1:0]      count_o,
  input logic                  irq_o
);

  logic hi_wr;
  logic lo_wr;
  assign hi_wr = wr_en && (wr_addr == REG_CMP_HI);
  assign lo_wr = wr_en && (wr_addr == REG_CMP_LO);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !tick_sel) |=> $stable(count_o));

  a_r4_irq_with_zero: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (count_o == '0));

  a_r5_low_byte_inert: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> ($stable(shadow_cmp) && $stable(active_cmp)));

  a_r6_stopped_is_zero: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (count_o == '0));

  a_r7_mode_locked: assert property (@(posedge clk) disable iff (rst)
    run_q |=> ($stable(dbuf_q) && $stable(clk_sel_q)));

  a_r8_shadow_load: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && run_q && dbuf_q) |=> (shadow_cmp == $past({wr_data, lo_latch_q})));

  a_r9_stopped_commit: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !run_q) |=> (active_cmp == $past({wr_data, lo_latch_q})));

  a_r10_direct_commit: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !dbuf_q) |=> (active_cmp == $past({wr_data, lo_latch_q})));

endmodule

bind casc_match_timer ctm_chk #(
  .STAGE_W (STAGE_W),
  .SEL_W   (SEL_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .run_q      (run_q),
  .cnt_en     (cnt_en),
  .tick_sel   (tick_sel),
  .dbuf_q     (dbuf_q),
  .clk_sel_q  (clk_sel_q),
  .lo_latch_q (lo_latch_q),
  .active_cmp (active_cmp),
  .shadow_cmp (shadow_cmp),
  .count_o    (count_o),
  .irq_o      (irq_o)
);

// File: tb/test_casc_match_timer.sv
`timescale 1ns/1ps
module test_casc_match_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [3:0]  tick_in = 4'b0001;
  logic        irq_o;
  logic [15:0] count_o;

  always #4 clk = ~clk;

  casc_match_timer i_casc_match_timer (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tick_in (tick_in),
    .irq_o   (irq_o),
    .count_o (count_o)
  );

  // register map used by the bench (see requirements R2, R3, R5, R8)
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;
  localparam logic [7:0] CTRL_GO   = 8'h03;
  localparam logic [7:0] CTRL_STOP = 8'h00;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [15:0] cnt;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic expect_at(input int due, input logic [15:0] cnt, input logic irq, input string tag);
    exp_t e;
    e.due = due; e.cnt = cnt; e.irq = irq; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued expectations just after the edge they belong to
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (e.due != cyc || count_o !== e.cnt || irq_o !== e.irq) begin
        n_fail++;
        $display("FAIL %s edge %0d (due %0d): count=%h irq=%b expected count=%h irq=%b",
                 e.tag, cyc, e.due, count_o, irq_o, e.cnt, e.irq);
      end
    end
  end

  // one register write; returns with cyc equal to the edge that took it
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  initial begin : main
    int w, s, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, idle
    w = cyc;
    expect_at(w + 1, 16'h0000, 1'b0, "R1 reset");
    expect_at(w + 4, 16'h0000, 1'b0, "R1 idle");
    drain();

    // compare = 5, stopped, shadow off
    wr(A_LO, 8'h05);
    wr(A_HI, 8'h00);

    // R2: run without cascade does not count
    wr(A_CTRL, 8'h01);
    w = cyc;
    expect_at(w + 10, 16'h0000, 1'b0, "R2 no cascade");
    drain();
    wr(A_CTRL, CTRL_STOP);

    // R3/R4: count up on every tick, match at 5
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    expect_at(w + 3, 16'd3, 1'b0, "R3 count");
    expect_at(w + 4, 16'd4, 1'b0, "R4 before match");
    expect_at(w + 5, 16'd0, 1'b1, "R4 match clears");
    expect_at(w + 6, 16'd1, 1'b0, "R4 single pulse");
    drain();

    // R6: stop clears
    wr(A_CTRL, CTRL_STOP);
    s = cyc;
    expect_at(s + 1, 16'd0, 1'b0, "R6 stop clears");
    expect_at(s + 4, 16'd0, 1'b0, "R6 stays zero");
    drain();

    // R5: low byte alone has no effect
    wr(A_LO, 8'h10);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    expect_at(w + 4, 16'd4, 1'b0, "R5 low only");
    expect_at(w + 5, 16'd0, 1'b1, "R5 old compare kept");
    drain();
    wr(A_CTRL, CTRL_STOP);
    wr(A_HI, 8'h00);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    expect_at(w + 15, 16'd15, 1'b0, "R5 pair committed");
    expect_at(w + 16, 16'd0, 1'b1, "R5 pair match");
    drain();
    wr(A_CTRL, CTRL_STOP);

    // R3: select tick 1 (held low) -> no counting
    wr(A_MODE, 8'h01);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    expect_at(w + 6, 16'd0, 1'b0, "R3 idle tick");
    // R7: mode write while running is ignored
    wr(A_MODE, 8'h00);
    s = cyc;
    expect_at(s + 6, 16'd0, 1'b0, "R7 mode locked");
    drain();
    wr(A_CTRL, CTRL_STOP);

    // R3: gaps in the selected tick hold the count
    wr(A_MODE, 8'h00);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    tick_in = 4'b0000;
    expect_at(w + 3, 16'd0, 1'b0, "R3 gap holds");
    expect_at(w + 6, 16'd3, 1'b0, "R3 resumes");
    wait_until(w + 3);
    tick_in = 4'b0001;
    drain();
    wr(A_CTRL, CTRL_STOP);

    // R9/R8: shadow enabled
    wr(A_MODE, 8'h04);
    wr(A_LO, 8'h08);
    wr(A_HI, 8'h00);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    wr(A_LO, 8'h03);
    wr(A_HI, 8'h00);   // count is 4 here, above the new value
    expect_at(w + 7, 16'd7, 1'b0, "R8 deferred");
    expect_at(w + 8, 16'd0, 1'b1, "R8 R9 old value matches");
    expect_at(w + 10, 16'd2, 1'b0, "R8 new value loaded");
    expect_at(w + 11, 16'd0, 1'b1, "R8 new value matches");
    drain();
    wr(A_CTRL, CTRL_STOP);

    // R10: shadow off, immediate update while running
    wr(A_MODE, 8'h00);
    wr(A_LO, 8'h00);
    wr(A_HI, 8'h01);
    wr(A_CTRL, CTRL_GO);
    w = cyc;
    wait_until(w + 16'h1C);
    wr(A_LO, 8'h30);
    wr(A_HI, 8'h00);
    expect_at(w + 16'h2F, 16'h002F, 1'b0, "R10 before");
    expect_at(w + 16'h30, 16'h0000, 1'b1, "R10 immediate match");
    drain();

    // R11: new compare below count -> wrap first
    b = w + 16'h30;
    wait_until(b + 16'h0D);
    wr(A_LO, 8'h05);
    wr(A_HI, 8'h00);
    expect_at(b + 16'h20, 16'h0020, 1'b0, "R11 passes value");
    expect_at(b + 65535, 16'hFFFF, 1'b0, "R11 top");
    expect_at(b + 65536, 16'h0000, 1'b0, "R11 wrap no irq");
    expect_at(b + 65540, 16'h0004, 1'b0, "R11 after wrap");
    expect_at(b + 65541, 16'h0000, 1'b1, "R11 match after wrap");
    drain();
    wr(A_CTRL, CTRL_STOP);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung with %0d checks pending", sb_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule